// File: doc/BRIEF.md
# Multi-Channel Configurable Match Timer

This block holds eight extra timer channels, numbered 4 to 11. Each has its own 32-bit counter, a 32-bit match value and a control word. A counter steps by one on each pulse of a tick-enable input picked by its control word. When the counter reaches the match value on a counting tick, the channel signals a match. A match can clear the counter and can leave the channel armed for later matches. A channel can also compare against a counter it shares with a lead channel.

Software reaches the block over a simple 32-bit register port. Writes take effect on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` on the edge after `bus_rd` is sampled and then holds. The tick-enable inputs come from clock generators outside the block and are single-cycle pulses. Matches that are enabled set bits 4..11 of a shared status word. One interrupt line stays high while any of those bits is set. The block carries no streaming data, so every port is a plain level or strobe with no handshake or back-pressure.

Top module: `mt_bank`

## Requirements
- R1: After reset every counter, match value, control word, the enable word, the status word and the snapshot read as zero, and `irq_o` is low.
- R2: Control bits [2:0] select the counting tick. Codes 1..5 pick `tick_in[0]` (32.768 kHz), `tick_in[1]` (1 kHz), `tick_in[2]` (1 Hz), `tick_in[3]` (1 MHz) and `tick_in[4]` (external). Codes 0, 6 and 7 hold the counter. A running counter advances by exactly one per pulse of its tick.
- R3: A write to a counter address (0x40 + 4*(n-4)) loads the counter at that edge, and the load overrides a tick in the same cycle.
- R4: A channel matches when its compared counter ticks while equal to its match value (0x80 + 4*(n-4)). A match sets status bit n only if bit n of the enable word (0x1C) is set.
- R5: With control bit 3 set, a match loads the channel's own counter with zero in place of the increment.
- R6: With control bit 6 clear, a channel matches once and then stays silent until its counter, match value or control word is written. With bit 6 set, it matches every time the condition recurs.
- R7: With control bit 7 clear, channels 5, 6 and 7 compare against counter 4, channel 9 against counter 8 and channel 11 against counter 10, and their own counters hold. Channels 4, 8 and 10 always use their own counters.
- R8: The control words of channels 4..7 keep bits [7:0] and read other bits as zero. Channels 8..11 keep bits [9:0]. On channels 8..11, bit 8 set holds the counter whatever the code in bits [2:0].
- R9: Reading counter 9 (0x54) or counter 11 (0x5C) while that channel's control bit 9 is set copies counter 8 or counter 10 into the snapshot word (0x20). Without bit 9, the snapshot keeps its value.
- R10: Writing ones to the status word (0x14, bits 11:4) clears those bits, and a new match in the same cycle wins. `irq_o` is high while any of bits 11:4 is set and falls only when all are clear.
- R11: Control words sit at 0xC0 + 4*(n-4). A read of an address that maps to no register returns zero. Read data appears the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after `bus_rd` |
| tick_in | input | N_TICK (5) | Tick-enable pulses: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq_o | output | 1 | Combined match interrupt for channels 4..11 |

## Verification
The checks assume single-cycle tick pulses. They also assume a read and a write never coincide, addresses are word aligned, and reset is held for some cycles before any access. The bench drives every strobe and tick for exactly one cycle from the falling edge and never overlaps a read with a write. The one-shot and frozen-counter properties exclude the cycles in which software writes the channel. Every write in the stimulus is such a write, so it re-arms the channel or reloads the counter.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int NCH      = 8;   // channels 4..11
  localparam int CTW      = 10;  // stored control width
  localparam int STAT_LSB = 4;   // status/enable bit of channel 4
  // control field positions
  localparam int B_RST  = 3;
  localparam int B_PER  = 6;
  localparam int B_OWN  = 7;
  localparam int B_HALT = 8;
  localparam int B_SNAP = 9;
  // register offsets
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_IEN   = 'h1C;
  localparam int OFF_SNAP  = 'h20;
  localparam int OFF_CNT   = 'h40;
  localparam int OFF_MATCH = 'h80;
  localparam int OFF_CTRL  = 'hC0;
endpackage

// File: rtl/mt_tick_mux.sv
module mt_tick_mux #(
  parameter int N_TICK = 5
) (
  input  logic [2:0]        sel,
  input  logic [N_TICK-1:0] tick_in,
  output logic              tick
);
  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < N_TICK; k++) begin
      if (int'(sel) == k + 1) tick = tick_in[k];
    end
  end
endmodule

// File: rtl/mt_chan.sv
module mt_chan
  import mt_pkg::*;
#(
  parameter int DW     = 32,
  parameter int N_TICK = 5,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_match,
  input  logic              wr_cnt,
  input  logic [DW-1:0]     wdata,
  input  logic [N_TICK-1:0] tick_in,
  input  logic [DW-1:0]     src_cnt,
  input  logic              src_tick,
  output logic [CTW-1:0]    ctrl_q,
  output logic [DW-1:0]     match_q,
  output logic [DW-1:0]     cnt_q,
  output logic              own_tick,
  output logic              hit
);
  localparam bit WIDE = (IDX >= 4);
  localparam bit ROOT = (IDX == 0) || (IDX == 4) || (IDX == 6);
  localparam logic [CTW-1:0] KEEP = WIDE ? {CTW{1'b1}} : CTW'(8'hFF);

  logic       armed;
  logic [2:0] sel_eff;
  logic       sel_tick;
  logic       own_run;
  logic       any_wr;

  assign sel_eff = (WIDE && ctrl_q[B_HALT]) ? 3'd0 : ctrl_q[2:0];
  assign own_run = ROOT || ctrl_q[B_OWN];
  assign any_wr  = wr_ctrl | wr_match | wr_cnt;

  mt_tick_mux #(.N_TICK(N_TICK)) u_mux (
    .sel    (sel_eff),
    .tick_in(tick_in),
    .tick   (sel_tick)
  );

  assign own_tick = own_run & sel_tick;
  assign hit      = armed & src_tick & (src_cnt == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      cnt_q   <= '0;
      armed   <= 1'b1;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata[CTW-1:0] & KEEP;
      if (wr_match) match_q <= wdata;
      if (any_wr)
        armed <= 1'b1;
      else if (hit && !ctrl_q[B_PER])
        armed <= 1'b0;
      if (wr_cnt)
        cnt_q <= wdata;
      else if (hit && ctrl_q[B_RST])
        cnt_q <= '0;
      else if (own_tick)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_bank.sv
module mt_bank
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int N_TICK = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_TICK-1:0] tick_in,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_SNAP = ADDR_W'(OFF_SNAP);

  logic [NCH-1:0][DW-1:0]  cnt_a, match_a, src_cnt_a, snap_src;
  logic [NCH-1:0][CTW-1:0] ctrl_a;
  logic [NCH-1:0]          otick, src_tick, hit_v, snap_req;
  logic [NCH-1:0]          wr_c, wr_m, wr_n;
  logic [NCH-1:0]          stat_q, ien_q, stat_clr;
  logic [DW-1:0]           snap_q, rd_val;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT + 4 * i);
    localparam logic [ADDR_W-1:0] A_MAT = ADDR_W'(OFF_MATCH + 4 * i);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTRL + 4 * i);
    localparam int SHARE = (i < 4) ? 0 : (i & ~1);

    assign wr_n[i] = bus_wr && (bus_addr == A_CNT);
    assign wr_m[i] = bus_wr && (bus_addr == A_MAT);
    assign wr_c[i] = bus_wr && (bus_addr == A_CTL);

    assign src_cnt_a[i] = ctrl_a[i][B_OWN] ? cnt_a[i] : cnt_a[SHARE];
    assign src_tick[i]  = ctrl_a[i][B_OWN] ? otick[i] : otick[SHARE];

    if (i >= 4 && (i % 2) == 1) begin : g_snap
      assign snap_req[i] = bus_rd && (bus_addr == A_CNT) && ctrl_a[i][B_SNAP];
      assign snap_src[i] = cnt_a[i-1];
    end else begin : g_nosnap
      assign snap_req[i] = 1'b0;
      assign snap_src[i] = '0;
    end

    mt_chan #(.DW(DW), .N_TICK(N_TICK), .IDX(i)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_c[i]),
      .wr_match(wr_m[i]),
      .wr_cnt  (wr_n[i]),
      .wdata   (bus_wdata),
      .tick_in (tick_in),
      .src_cnt (src_cnt_a[i]),
      .src_tick(src_tick[i]),
      .ctrl_q  (ctrl_a[i]),
      .match_q (match_a[i]),
      .cnt_q   (cnt_a[i]),
      .own_tick(otick[i]),
      .hit     (hit_v[i])
    );
  end

  assign stat_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[STAT_LSB +: NCH] : '0;
  assign irq_o    = |stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      snap_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | (hit_v & ien_q);
      if (bus_wr && bus_addr == A_IEN) ien_q <= bus_wdata[STAT_LSB +: NCH];
      for (int k = 0; k < NCH; k++) begin
        if (snap_req[k]) snap_q <= snap_src[k];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_STAT) rd_val = DW'({stat_q, {STAT_LSB{1'b0}}});
    if (bus_addr == A_IEN)  rd_val = DW'({ien_q, {STAT_LSB{1'b0}}});
    if (bus_addr == A_SNAP) rd_val = snap_q;
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == ADDR_W'(OFF_CNT + 4 * k))   rd_val = cnt_a[k];
      if (bus_addr == ADDR_W'(OFF_MATCH + 4 * k)) rd_val = match_a[k];
      if (bus_addr == ADDR_W'(OFF_CTRL + 4 * k))  rd_val = DW'(ctrl_a[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/mt_bank_chk.sv
module mt_bank_chk
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq_o,
  input logic              hit_any,
  input logic              hit0,
  input logic              hit1,
  input logic              per0,
  input logic              own1,
  input logic              rst1,
  input logic [1:0]        ctrl1_hi,
  input logic [DW-1:0]     cnt0,
  input logic [DW-1:0]     cnt1
);
  logic wr_ch0, wr_cnt0, wr_cnt1, wr_stat;
  assign wr_cnt0 = bus_wr && bus_addr == ADDR_W'(OFF_CNT);
  assign wr_cnt1 = bus_wr && bus_addr == ADDR_W'(OFF_CNT + 4);
  assign wr_stat = bus_wr && bus_addr == ADDR_W'(OFF_STAT);
  assign wr_ch0  = wr_cnt0 || (bus_wr && (bus_addr == ADDR_W'(OFF_MATCH) ||
                                          bus_addr == ADDR_W'(OFF_CTRL)));

  // R3: counter write lands on the next edge
  a_r3_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt0 |=> cnt0 == $past(bus_wdata));

  // R6: one-shot channel does not match twice in a row without a write
  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && !per0 && !wr_ch0) |=> !hit0);

  // R7: a sharing channel's own counter stays put
  a_r7_sharer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!own1 && !wr_cnt1 && !(hit1 && rst1)) |=> cnt1 == $past(cnt1));

  // R8: narrow channels never hold bits 9:8
  a_r8_narrow_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl1_hi == 2'b00);

  // R10: interrupt rises only after a match
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hit_any));

  // R10: interrupt falls only after a status write
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_stat));
endmodule

bind mt_bank mt_bank_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_o    (irq_o),
  .hit_any  (|hit_v),
  .hit0     (hit_v[0]),
  .hit1     (hit_v[1]),
  .per0     (ctrl_a[0][mt_pkg::B_PER]),
  .own1     (ctrl_a[1][mt_pkg::B_OWN]),
  .rst1     (ctrl_a[1][mt_pkg::B_RST]),
  .ctrl1_hi (ctrl_a[1][9:8]),
  .cnt0     (cnt_a[0]),
  .cnt1     (cnt_a[1])
);

// File: tb/mt_bank_bench.sv
module mt_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_in = '0;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mt_bank u_mt_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(int idx, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      tick_in[idx] = 1'b1;
      @(negedge clk);
      tick_in = '0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h40, d); chk("R1 cnt4", d, 0);
    rd(8'hC0, d); chk("R1 ctrl4", d, 0);
    rd(8'h80, d); chk("R1 match4", d, 0);
    rd(8'h14, d); chk("R1 status", d, 0);
    rd(8'h20, d); chk("R1 snap", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_clock_sel;
    logic [31:0] d;
    wr(8'h40, 0);
    for (int j = 0; j < 5; j++) tick(j, 1);
    rd(8'h40, d); chk("R2 code0 holds", d, 0);
    wr(8'hC0, 32'h1); tick(0, 3); tick(1, 2);
    rd(8'h40, d); chk("R2 code1 tick0", d, 3);
    wr(8'hC0, 32'h2); tick(1, 2); tick(0, 1);
    rd(8'h40, d); chk("R2 code2 tick1", d, 5);
    wr(8'hC0, 32'h3); tick(2, 1);
    wr(8'hC0, 32'h4); tick(3, 2); tick(4, 1);
    rd(8'h40, d); chk("R2 code3/4", d, 8);
    wr(8'hC0, 32'h5); tick(4, 2);
    rd(8'h40, d); chk("R2 code5 ext", d, 10);
    wr(8'hC0, 32'h6); for (int j = 0; j < 5; j++) tick(j, 1);
    wr(8'hC0, 32'h7); for (int j = 0; j < 5; j++) tick(j, 1);
    rd(8'h40, d); chk("R2 code6/7 hold", d, 10);
  endtask

  task automatic t_load;
    logic [31:0] d;
    wr(8'hC0, 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'd100; tick_in[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_in = '0;
    rd(8'h40, d); chk("R3 load beats tick", d, 100);
    rd(8'h00, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_match;
    logic [31:0] d;
    wr(8'h1C, 32'h0);
    wr(8'hC0, 32'h1); wr(8'h80, 5); wr(8'h40, 0);
    tick(0, 6);
    rd(8'h14, d); chk("R4 masked no status", d, 0);
    wr(8'h1C, 32'h10); wr(8'h40, 0);
    tick(0, 5);
    rd(8'h14, d); chk("R4 before match", d, 0);
    tick(0, 1);
    rd(8'h14, d); chk("R4 status set", d, 32'h10);
    chk("R10 irq high", {31'b0, irq_o}, 1);
    rd(8'h40, d); chk("R5 no reset keeps counting", d, 6);
    rd(8'h80, d); chk("R11 match readback", d, 5);
    wr(8'h14, 32'h10);
    chk("R10 irq cleared", {31'b0, irq_o}, 0);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    wr(8'hC0, 32'h09); wr(8'h80, 2); wr(8'h40, 0);
    tick(0, 3);
    rd(8'h14, d); chk("R6 one-shot first", d, 32'h10);
    rd(8'h40, d); chk("R5 reset on match", d, 0);
    wr(8'h14, 32'h10);
    tick(0, 3);
    rd(8'h14, d); chk("R6 one-shot silent", d, 0);
    rd(8'h40, d); chk("R6 no reset when disarmed", d, 3);
    wr(8'hC0, 32'h49); wr(8'h40, 0);
    tick(0, 3);
    rd(8'h14, d); chk("R6 periodic first", d, 32'h10);
    wr(8'h14, 32'h10);
    tick(0, 3);
    rd(8'h14, d); chk("R6 periodic again", d, 32'h10);
    wr(8'h14, 32'h10);
  endtask

  task automatic t_share;
    logic [31:0] d;
    wr(8'h1C, 32'h20);
    wr(8'hC0, 32'h1); wr(8'h80, 100); wr(8'h40, 0);
    wr(8'hC4, 32'h1); wr(8'h84, 3); wr(8'h44, 50);
    tick(0, 3);
    rd(8'h14, d); chk("R7 shared before", d, 0);
    tick(0, 1);
    rd(8'h14, d); chk("R7 shared match", d, 32'h20);
    rd(8'h44, d); chk("R7 own counter held", d, 50);
    wr(8'hC4, 32'h81); tick(0, 2);
    rd(8'h44, d); chk("R7 own counter runs", d, 52);
    wr(8'h14, 32'h20);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h1C, 32'h30);
    wr(8'hC0, 32'h1); wr(8'h80, 2);
    wr(8'hC4, 32'h1); wr(8'h84, 2); wr(8'h40, 0);
    tick(0, 3);
    rd(8'h14, d); chk("R10 both set", d, 32'h30);
    wr(8'h14, 32'h10);
    rd(8'h14, d); chk("R10 partial clear", d, 32'h20);
    chk("R10 irq held", {31'b0, irq_o}, 1);
    wr(8'h14, 32'h20);
    chk("R10 irq drop", {31'b0, irq_o}, 0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_ctrl_width;
    logic [31:0] d;
    wr(8'hC4, 32'h3FF); rd(8'hC4, d); chk("R8 narrow mask", d, 32'hFF);
    wr(8'hD0, 32'h3FF); rd(8'hD0, d); chk("R11 wide ctrl", d, 32'h3FF);
    wr(8'hC4, 32'h0);
    wr(8'hD0, 32'h101); wr(8'h50, 0); tick(0, 3);
    rd(8'h50, d); chk("R8 halt bit", d, 0);
    wr(8'hD0, 32'h001); tick(0, 3);
    rd(8'h50, d); chk("R8 runs without halt", d, 3);
  endtask

  task automatic t_snap;
    logic [31:0] d;
    wr(8'h50, 77); wr(8'hD4, 32'h200);
    rd(8'h54, d); rd(8'h20, d); chk("R9 snapshot", d, 77);
    wr(8'h50, 88); wr(8'hD4, 32'h0);
    rd(8'h54, d); rd(8'h20, d); chk("R9 no snapshot", d, 77);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clock_sel();
    t_load();
    t_match();
    t_modes();
    t_share();
    t_irq();
    t_ctrl_width();
    t_snap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule